// File: doc/BRIEF.md
# Multirate PCS Management Register File

This block is the control and status register file of a multirate Ethernet PCS. A host reaches it through a word-addressed port with separate read and write strobes. Every read returns its data exactly one clock later. The block decodes two register windows. The first is a 16-bit window at word offsets 0x00–0x1F for 1000BASE-X/SGMII operation. The second is a 32-bit window at 0x400–0x43F for USXGMII operation.

The file holds three kinds of register bits. Configuration bits drive the block's output pins directly. Command bits are set by software and cleared by a hardware acknowledge. Status bits either follow live hardware inputs or are sticky flags that a read clears. The negotiation engine, the PCS datapath and the latency measurement logic are outside this block. They appear only as acknowledge and status inputs and as configuration outputs.

Top module: `pcs_mgmt_regs`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `req_rd` high. In that cycle `rsp_rdata` holds the addressed register as it stood when the read was issued.
- R2: After reset, the registers read as follows: 0x04 reads 0x01A0 (pause field [8:7]=11, full-duplex bit 5=1), 0x12 reads 0x8A00, 0x13 reads 0x0009, 0x400 reads 0x2 (negotiation enable bit 1), 0x412 reads 0x7C000 (bits [19:14]=0x1F). Every other writable field reads 0.
- R3: Writing 1 to bit 15 of 0x00 raises `cfg_soft_rst`. The bit holds until `hw_rst_done` is seen, then clears on the next edge. Writing 0 to it does not clear it, and all other register contents survive the soft reset.
- R4: Bit 9 of 0x00 and bit 9 of 0x400 are restart commands. Each one sets on a written 1 and clears on its own acknowledge (`hw_an_restart_ack` or `usx_an_restart_ack`). A written 1 wins over an acknowledge in the same cycle. A written 0 leaves a pending command set.
- R5: 0x01 reads bit 3 as 1 at all times, bit 5 as `hw_an_done` and bit 2 as `hw_link_up`. 0x401 reads bit 5 as `usx_an_done` and bit 2 as `usx_link_up`. 0x05 reads `hw_partner_ability`. 0x405 reads `usx_partner_ability` masked to bits 15, 14, 12, 11:9, 8 and 7.
- R6: Bit 1 of 0x06 is set by a `hw_page_rx` pulse. It stays set until a read of 0x06 is issued. A pulse in the same cycle as that read leaves it set. Writes and reads of other offsets do not clear it. Bit 0 of 0x06 reads `hw_partner_an_able`.
- R7: The writable legacy fields are 0x00 bit 12 (negotiation enable), 0x04 bits [13:12], [8:7] and 5, 0x10 bits [15:0] (scratch), 0x12 bits [15:0] (timer low), 0x13 bits [4:0] (timer high), and 0x14 bits [3:0]. In 0x14, bit 0 is SGMII enable, bit 1 selects negotiated abilities and bits [3:2] are the speed. Each field reads back and drives its matching `cfg_` output.
- R8: A read anywhere in the legacy window returns 0 in bits [31:16].
- R9: Bits 3 (RX) and 2 (TX) of 0x17 and of 0x420 are latency-block resets. They are plain read/write bits and never clear themselves. Bits 1 and 0 of both registers read `hw_meas_valid[1]` and `hw_meas_valid[0]`.
- R10: In 0x412 only bits [19:14] are writable, and they drive `usx_cfg_link_timer`. Bits [13:0] read 0 whatever is written.
- R11: 0x400 bit 0 (USXGMII enable), bit 1 (negotiation enable) and bits [4:2] (speed) read back and drive `usx_cfg_en`, `usx_cfg_an_en` and `usx_cfg_speed`.
- R12: The next-page offsets 0x07 and 0x08, every reserved offset in either window, and every offset outside both windows read 0. Writes to these offsets change nothing.
- R13: 0x02 reads `PHY_ID[15:0]`, 0x03 reads `PHY_ID[31:16]`, and 0x11 reads `REV_ID`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after `req_rd` |
| rsp_rdata | output | 32 | Read data |
| hw_rst_done | input | 1 | Soft reset completion acknowledge |
| hw_an_restart_ack | input | 1 | Legacy negotiation restart acknowledge |
| hw_an_done | input | 1 | Legacy negotiation complete |
| hw_link_up | input | 1 | Legacy link established |
| hw_page_rx | input | 1 | Partner ability updated (pulse) |
| hw_partner_an_able | input | 1 | Partner supports negotiation |
| hw_partner_ability | input | 16 | Legacy partner ability word |
| hw_meas_valid | input | 2 | Latency measurement valid, [1] RX, [0] TX |
| usx_an_restart_ack | input | 1 | USXGMII negotiation restart acknowledge |
| usx_an_done | input | 1 | USXGMII negotiation complete |
| usx_link_up | input | 1 | USXGMII link established |
| usx_partner_ability | input | 16 | USXGMII partner ability word |
| cfg_soft_rst | output | 1 | Soft reset request, held until acknowledged |
| cfg_an_en | output | 1 | Legacy negotiation enable |
| cfg_an_restart | output | 1 | Legacy negotiation restart request |
| cfg_adv_ability | output | 16 | Advertised ability word |
| cfg_link_timer | output | 21 | Legacy link timer in 16 ns units |
| cfg_sgmii_en | output | 1 | SGMII mode select |
| cfg_sgmii_use_an | output | 1 | Use negotiated abilities |
| cfg_sgmii_speed | output | 2 | Manual SGMII speed |
| cfg_dl_rst | output | 2 | Legacy latency resets, [1] RX, [0] TX |
| usx_cfg_en | output | 1 | USXGMII mode select |
| usx_cfg_an_en | output | 1 | USXGMII negotiation enable |
| usx_cfg_speed | output | 3 | USXGMII manual speed |
| usx_cfg_an_restart | output | 1 | USXGMII negotiation restart request |
| usx_cfg_link_timer | output | 6 | USXGMII link timer field |
| usx_cfg_dl_rst | output | 2 | USXGMII latency resets, [1] RX, [0] TX |

## Verification
The bench builds the block with `ADDR_W = 11` and distinctive `PHY_ID` and `REV_ID` values. With 11 address bits the whole 2048-word space can be swept in three complete passes: one after reset, one after writing all ones everywhere, and one after writing all zeros everywhere. Together these passes cover every reserved and unmapped offset, every field mask and any write that aliases onto another register. Directed sequences then cover the same-cycle races between command bits and acknowledges, and between the clear-on-read flag and its set pulse.

// File: rtl/pcs_mgmt_pkg.sv
// Shared offsets, reset values and field types of the PCS register file.
// Assumes the USXGMII window begins at word 0x400 and spans 64 words.
package pcs_mgmt_pkg;

    localparam int unsigned LEG_OFF_W = 5;
    localparam int unsigned USX_OFF_W = 6;
    localparam int unsigned USX_BASE  = 32'h400;

    // legacy (16-bit) window offsets
    localparam logic [4:0] L_CTRL   = 5'h00;
    localparam logic [4:0] L_STAT   = 5'h01;
    localparam logic [4:0] L_ID_LO  = 5'h02;
    localparam logic [4:0] L_ID_HI  = 5'h03;
    localparam logic [4:0] L_ADV    = 5'h04;
    localparam logic [4:0] L_PART   = 5'h05;
    localparam logic [4:0] L_EXP    = 5'h06;
    localparam logic [4:0] L_SCR    = 5'h10;
    localparam logic [4:0] L_REV    = 5'h11;
    localparam logic [4:0] L_TMR_LO = 5'h12;
    localparam logic [4:0] L_TMR_HI = 5'h13;
    localparam logic [4:0] L_IFM    = 5'h14;
    localparam logic [4:0] L_DL     = 5'h17;

    // USXGMII (32-bit) window offsets, relative to USX_BASE
    localparam logic [5:0] U_CTRL = 6'h00;
    localparam logic [5:0] U_STAT = 6'h01;
    localparam logic [5:0] U_PART = 6'h05;
    localparam logic [5:0] U_TMR  = 6'h12;
    localparam logic [5:0] U_DL   = 6'h20;

    localparam logic [1:0]  ADV_PS_RST = 2'b11;
    localparam logic [20:0] LTMR_RST   = 21'h098A00;
    localparam logic [5:0]  UTMR_RST   = 6'h1F;
    localparam logic [15:0] UPART_MASK = 16'hDF80;

    // interface mode field, bit 0 is the SGMII enable
    typedef struct packed {
        logic [1:0] speed;
        logic       use_an;
        logic       ena;
    } ifmode_t;

endpackage

// File: rtl/pcs_sc_bit.sv
// Command bit: set by a software write, cleared by a hardware acknowledge.
// Assumes set has priority, so a fresh request is never lost to a late ack.
module pcs_sc_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    output logic q_o
);

    // hold the pending command until acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (ack_i) q_o <= 1'b0;
    end

    // R3 and R4: a pending command survives until its acknowledge
    a_r4_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && !ack_i) |=> q_o);
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !set_i) |=> !q_o);

endmodule

// File: rtl/pcs_leg_win.sv
// 16-bit 1000BASE-X/SGMII register window. Decodes a 5-bit offset, holds
// the configuration fields, command bits and the clear-on-read page flag.
// Assumes wr_en / rd_en already qualified with the window select.
module pcs_leg_win #(
    parameter logic [31:0] PHY_ID = 32'h0000_0000,
    parameter logic [15:0] REV_ID = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [4:0]  off,
    input  logic [15:0] wdata,
    input  logic        hw_rst_done,
    input  logic        hw_an_restart_ack,
    input  logic        hw_an_done,
    input  logic        hw_link_up,
    input  logic        hw_page_rx,
    input  logic        hw_partner_an_able,
    input  logic [15:0] hw_partner_ability,
    input  logic [1:0]  hw_meas_valid,
    output logic [15:0] rdata,
    output logic        cfg_soft_rst,
    output logic        cfg_an_en,
    output logic        cfg_an_restart,
    output logic [15:0] cfg_adv_ability,
    output logic [20:0] cfg_link_timer,
    output logic        cfg_sgmii_en,
    output logic        cfg_sgmii_use_an,
    output logic [1:0]  cfg_sgmii_speed,
    output logic [1:0]  cfg_dl_rst
);
    import pcs_mgmt_pkg::*;

    logic [1:0]  adv_rf, adv_ps;
    logic        adv_fd;
    logic [15:0] scratch;
    logic [20:0] ltmr;
    ifmode_t     ifm;
    logic        page_flag;
    logic        w_ctrl, rd_exp;

    assign w_ctrl = wr_en && (off == L_CTRL);
    assign rd_exp = rd_en && (off == L_EXP);

    pcs_sc_bit u_soft_rst (
        .clk(clk), .rst_n(rst_n), .set_i(w_ctrl && wdata[15]),
        .ack_i(hw_rst_done), .q_o(cfg_soft_rst));

    pcs_sc_bit u_an_restart (
        .clk(clk), .rst_n(rst_n), .set_i(w_ctrl && wdata[9]),
        .ack_i(hw_an_restart_ack), .q_o(cfg_an_restart));

    // plain read/write configuration fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_an_en  <= 1'b0;
            adv_rf     <= 2'b00;
            adv_ps     <= ADV_PS_RST;
            adv_fd     <= 1'b1;
            scratch    <= '0;
            ltmr       <= LTMR_RST;
            ifm        <= '0;
            cfg_dl_rst <= 2'b00;
        end else if (wr_en) begin
            case (off)
                L_CTRL:   cfg_an_en <= wdata[12];
                L_ADV: begin
                    adv_rf <= wdata[13:12];
                    adv_ps <= wdata[8:7];
                    adv_fd <= wdata[5];
                end
                L_SCR:    scratch      <= wdata;
                L_TMR_LO: ltmr[15:0]   <= wdata;
                L_TMR_HI: ltmr[20:16]  <= wdata[4:0];
                L_IFM:    ifm          <= wdata[3:0];
                L_DL:     cfg_dl_rst   <= wdata[3:2];
                default:  ;
            endcase
        end
    end

    // sticky page flag: a set event outranks the clearing read
    always_ff @(posedge clk) begin
        if (!rst_n)          page_flag <= 1'b0;
        else if (hw_page_rx) page_flag <= 1'b1;
        else if (rd_exp)     page_flag <= 1'b0;
    end

    assign cfg_adv_ability  = {2'b00, adv_rf, 3'b000, adv_ps, 1'b0, adv_fd, 5'b00000};
    assign cfg_link_timer   = ltmr;
    assign cfg_sgmii_en     = ifm.ena;
    assign cfg_sgmii_use_an = ifm.use_an;
    assign cfg_sgmii_speed  = ifm.speed;

    // read multiplexer, unmapped offsets return zero
    always_comb begin
        rdata = '0;
        case (off)
            L_CTRL:   rdata = {cfg_soft_rst, 2'b00, cfg_an_en, 2'b00, cfg_an_restart, 9'd0};
            L_STAT:   rdata = {10'd0, hw_an_done, 1'b0, 1'b1, hw_link_up, 2'b00};
            L_ID_LO:  rdata = PHY_ID[15:0];
            L_ID_HI:  rdata = PHY_ID[31:16];
            L_ADV:    rdata = cfg_adv_ability;
            L_PART:   rdata = hw_partner_ability;
            L_EXP:    rdata = {14'd0, page_flag, hw_partner_an_able};
            L_SCR:    rdata = scratch;
            L_REV:    rdata = REV_ID;
            L_TMR_LO: rdata = ltmr[15:0];
            L_TMR_HI: rdata = {11'd0, ltmr[20:16]};
            L_IFM:    rdata = {12'd0, ifm};
            L_DL:     rdata = {12'd0, cfg_dl_rst, hw_meas_valid};
            default:  rdata = '0;
        endcase
    end

    a_r6_set_event: assert property (@(posedge clk) disable iff (!rst_n)
        hw_page_rx |=> page_flag);
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (page_flag && !hw_page_rx && !rd_exp) |=> page_flag);
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_exp && !hw_page_rx) |=> !page_flag);
    a_r9_dl_no_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && off == L_DL) |=> $stable(cfg_dl_rst));

endmodule

// File: rtl/pcs_usx_win.sv
// 32-bit USXGMII register window. Decodes a 6-bit offset relative to the
// window base; holds mode, speed, restart command, link timer and
// latency reset fields. Assumes wr_en is qualified with the window select.
module pcs_usx_win (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [5:0]  off,
    input  logic [31:0] wdata,
    input  logic        usx_an_restart_ack,
    input  logic        usx_an_done,
    input  logic        usx_link_up,
    input  logic [15:0] usx_partner_ability,
    input  logic [1:0]  hw_meas_valid,
    output logic [31:0] rdata,
    output logic        usx_cfg_en,
    output logic        usx_cfg_an_en,
    output logic [2:0]  usx_cfg_speed,
    output logic        usx_cfg_an_restart,
    output logic [5:0]  usx_cfg_link_timer,
    output logic [1:0]  usx_cfg_dl_rst
);
    import pcs_mgmt_pkg::*;

    logic w_ctrl;
    logic unused_wbits;

    assign w_ctrl       = wr_en && (off == U_CTRL);
    assign unused_wbits = ^{wdata[31:20], wdata[13:10], wdata[8:5]};

    pcs_sc_bit u_an_restart (
        .clk(clk), .rst_n(rst_n), .set_i(w_ctrl && wdata[9]),
        .ack_i(usx_an_restart_ack), .q_o(usx_cfg_an_restart));

    // plain read/write configuration fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            usx_cfg_en         <= 1'b0;
            usx_cfg_an_en      <= 1'b1;
            usx_cfg_speed      <= 3'd0;
            usx_cfg_link_timer <= UTMR_RST;
            usx_cfg_dl_rst     <= 2'b00;
        end else if (wr_en) begin
            case (off)
                U_CTRL: begin
                    usx_cfg_en    <= wdata[0];
                    usx_cfg_an_en <= wdata[1];
                    usx_cfg_speed <= wdata[4:2];
                end
                U_TMR:   usx_cfg_link_timer <= wdata[19:14];
                U_DL:    usx_cfg_dl_rst     <= wdata[3:2];
                default: ;
            endcase
        end
    end

    // read multiplexer, unmapped offsets return zero
    always_comb begin
        rdata = '0;
        case (off)
            U_CTRL:  rdata = {22'd0, usx_cfg_an_restart, 4'd0, usx_cfg_speed,
                              usx_cfg_an_en, usx_cfg_en};
            U_STAT:  rdata = {26'd0, usx_an_done, 2'b00, usx_link_up, 2'b00};
            U_PART:  rdata = {16'd0, usx_partner_ability & UPART_MASK};
            U_TMR:   rdata = {12'd0, usx_cfg_link_timer, 14'd0};
            U_DL:    rdata = {28'd0, usx_cfg_dl_rst, hw_meas_valid};
            default: rdata = '0;
        endcase
    end

    a_r9_usx_dl_no_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && off == U_DL) |=> $stable(usx_cfg_dl_rst));
    a_r11_ctrl_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !w_ctrl |=> ($stable(usx_cfg_en) && $stable(usx_cfg_an_en) && $stable(usx_cfg_speed)));

endmodule

// File: rtl/pcs_mgmt_regs.sv
// Top of the PCS management register file. Splits the word address into
// the legacy window (0x00-0x1F) and the USXGMII window (0x400-0x43F) and
// registers read data with a fixed one-cycle latency.
// Assumes ADDR_W >= 11 so that the USXGMII window is addressable.
module pcs_mgmt_regs #(
    parameter int unsigned ADDR_W = 11,
    parameter logic [31:0] PHY_ID = 32'h0000_0000,
    parameter logic [15:0] REV_ID = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    input  logic              hw_rst_done,
    input  logic              hw_an_restart_ack,
    input  logic              hw_an_done,
    input  logic              hw_link_up,
    input  logic              hw_page_rx,
    input  logic              hw_partner_an_able,
    input  logic [15:0]       hw_partner_ability,
    input  logic [1:0]        hw_meas_valid,
    input  logic              usx_an_restart_ack,
    input  logic              usx_an_done,
    input  logic              usx_link_up,
    input  logic [15:0]       usx_partner_ability,
    output logic              cfg_soft_rst,
    output logic              cfg_an_en,
    output logic              cfg_an_restart,
    output logic [15:0]       cfg_adv_ability,
    output logic [20:0]       cfg_link_timer,
    output logic              cfg_sgmii_en,
    output logic              cfg_sgmii_use_an,
    output logic [1:0]        cfg_sgmii_speed,
    output logic [1:0]        cfg_dl_rst,
    output logic              usx_cfg_en,
    output logic              usx_cfg_an_en,
    output logic [2:0]        usx_cfg_speed,
    output logic              usx_cfg_an_restart,
    output logic [5:0]        usx_cfg_link_timer,
    output logic [1:0]        usx_cfg_dl_rst
);
    import pcs_mgmt_pkg::*;

    localparam int unsigned LEG_PAGE_W = ADDR_W - LEG_OFF_W;
    localparam int unsigned USX_PAGE_W = ADDR_W - USX_OFF_W;
    localparam logic [USX_PAGE_W-1:0] USX_PAGE = USX_PAGE_W'(USX_BASE >> USX_OFF_W);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_UTMR   = ADDR_W'(USX_BASE + 32'(U_TMR));

    logic        leg_sel, usx_sel;
    logic [15:0] leg_rdata;
    logic [31:0] usx_rdata;

    assign leg_sel = (req_addr[ADDR_W-1:LEG_OFF_W] == {LEG_PAGE_W{1'b0}});
    assign usx_sel = (req_addr[ADDR_W-1:USX_OFF_W] == USX_PAGE);

    pcs_leg_win #(.PHY_ID(PHY_ID), .REV_ID(REV_ID)) u_leg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(req_wr && leg_sel), .rd_en(req_rd && leg_sel),
        .off(req_addr[LEG_OFF_W-1:0]), .wdata(req_wdata[15:0]),
        .hw_rst_done(hw_rst_done), .hw_an_restart_ack(hw_an_restart_ack),
        .hw_an_done(hw_an_done), .hw_link_up(hw_link_up),
        .hw_page_rx(hw_page_rx), .hw_partner_an_able(hw_partner_an_able),
        .hw_partner_ability(hw_partner_ability), .hw_meas_valid(hw_meas_valid),
        .rdata(leg_rdata),
        .cfg_soft_rst(cfg_soft_rst), .cfg_an_en(cfg_an_en),
        .cfg_an_restart(cfg_an_restart), .cfg_adv_ability(cfg_adv_ability),
        .cfg_link_timer(cfg_link_timer), .cfg_sgmii_en(cfg_sgmii_en),
        .cfg_sgmii_use_an(cfg_sgmii_use_an), .cfg_sgmii_speed(cfg_sgmii_speed),
        .cfg_dl_rst(cfg_dl_rst));

    pcs_usx_win u_usx (
        .clk(clk), .rst_n(rst_n),
        .wr_en(req_wr && usx_sel),
        .off(req_addr[USX_OFF_W-1:0]), .wdata(req_wdata),
        .usx_an_restart_ack(usx_an_restart_ack), .usx_an_done(usx_an_done),
        .usx_link_up(usx_link_up), .usx_partner_ability(usx_partner_ability),
        .hw_meas_valid(hw_meas_valid),
        .rdata(usx_rdata),
        .usx_cfg_en(usx_cfg_en), .usx_cfg_an_en(usx_cfg_an_en),
        .usx_cfg_speed(usx_cfg_speed), .usx_cfg_an_restart(usx_cfg_an_restart),
        .usx_cfg_link_timer(usx_cfg_link_timer), .usx_cfg_dl_rst(usx_cfg_dl_rst));

    // one-cycle read pipeline; data holds between reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_rd;
            if (req_rd) begin
                if (leg_sel)      rsp_rdata <= {16'd0, leg_rdata};
                else if (usx_sel) rsp_rdata <= usx_rdata;
                else              rsp_rdata <= '0;
            end
        end
    end

    a_r1_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        req_rd |=> rsp_valid);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_rd |=> !rsp_valid);
    a_r8_legacy_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && leg_sel) |=> (rsp_rdata[31:16] == 16'd0));
    a_r5_ability_always: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && req_addr == A_STATUS) |=> rsp_rdata[3]);
    a_r10_timer_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && req_addr == A_UTMR) |=> (rsp_rdata[13:0] == 14'd0));

endmodule

// File: tb/sim_pcs_mgmt_regs.sv
// Self-checking bench: full address sweeps plus directed race sequences.
module sim_pcs_mgmt_regs;

    localparam int          AW  = 11;
    localparam logic [31:0] PID = 32'h1234_5678;
    localparam logic [15:0] REV = 16'h0042;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_rd = 1'b0, req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        hw_rst_done = 1'b0, hw_an_restart_ack = 1'b0, hw_an_done = 1'b0;
    logic        hw_link_up = 1'b0, hw_page_rx = 1'b0, hw_partner_an_able = 1'b0;
    logic [15:0] hw_partner_ability = '0;
    logic [1:0]  hw_meas_valid = '0;
    logic        usx_an_restart_ack = 1'b0, usx_an_done = 1'b0, usx_link_up = 1'b0;
    logic [15:0] usx_partner_ability = '0;
    logic        cfg_soft_rst, cfg_an_en, cfg_an_restart;
    logic [15:0] cfg_adv_ability;
    logic [20:0] cfg_link_timer;
    logic        cfg_sgmii_en, cfg_sgmii_use_an;
    logic [1:0]  cfg_sgmii_speed, cfg_dl_rst;
    logic        usx_cfg_en, usx_cfg_an_en, usx_cfg_an_restart;
    logic [2:0]  usx_cfg_speed;
    logic [5:0]  usx_cfg_link_timer;
    logic [1:0]  usx_cfg_dl_rst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pcs_mgmt_regs #(.ADDR_W(AW), .PHY_ID(PID), .REV_ID(REV)) u0 (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .hw_rst_done(hw_rst_done), .hw_an_restart_ack(hw_an_restart_ack),
        .hw_an_done(hw_an_done), .hw_link_up(hw_link_up), .hw_page_rx(hw_page_rx),
        .hw_partner_an_able(hw_partner_an_able), .hw_partner_ability(hw_partner_ability),
        .hw_meas_valid(hw_meas_valid), .usx_an_restart_ack(usx_an_restart_ack),
        .usx_an_done(usx_an_done), .usx_link_up(usx_link_up),
        .usx_partner_ability(usx_partner_ability),
        .cfg_soft_rst(cfg_soft_rst), .cfg_an_en(cfg_an_en), .cfg_an_restart(cfg_an_restart),
        .cfg_adv_ability(cfg_adv_ability), .cfg_link_timer(cfg_link_timer),
        .cfg_sgmii_en(cfg_sgmii_en), .cfg_sgmii_use_an(cfg_sgmii_use_an),
        .cfg_sgmii_speed(cfg_sgmii_speed), .cfg_dl_rst(cfg_dl_rst),
        .usx_cfg_en(usx_cfg_en), .usx_cfg_an_en(usx_cfg_an_en),
        .usx_cfg_speed(usx_cfg_speed), .usx_cfg_an_restart(usx_cfg_an_restart),
        .usx_cfg_link_timer(usx_cfg_link_timer), .usx_cfg_dl_rst(usx_cfg_dl_rst));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // constants visible at every phase with hardware inputs at zero
    function automatic logic [31:0] exp_const(input int a);
        case (a)
            'h01:    return 32'h8;
            'h02:    return {16'd0, PID[15:0]};
            'h03:    return {16'd0, PID[31:16]};
            'h11:    return {16'd0, REV};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_reset(input int a);
        case (a)
            'h04:    return 32'h01A0;
            'h12:    return 32'h8A00;
            'h13:    return 32'h0009;
            'h400:   return 32'h2;
            'h412:   return 32'h7C000;
            default: return exp_const(a);
        endcase
    endfunction

    function automatic logic [31:0] exp_ones(input int a);
        case (a)
            'h00:    return 32'h9200;
            'h04:    return 32'h31A0;
            'h10:    return 32'hFFFF;
            'h12:    return 32'hFFFF;
            'h13:    return 32'h001F;
            'h14:    return 32'h000F;
            'h17:    return 32'h000C;
            'h400:   return 32'h21F;
            'h412:   return 32'hFC000;
            'h420:   return 32'hC;
            default: return exp_const(a);
        endcase
    endfunction

    function automatic logic [31:0] exp_zeros(input int a);
        case (a)
            'h00:    return 32'h8200;
            'h400:   return 32'h200;
            default: return exp_const(a);
        endcase
    endfunction

    task automatic do_write(input int a, input logic [31:0] d);
        @(negedge clk);
        req_wr = 1'b1; req_addr = AW'(a); req_wdata = d;
        @(negedge clk);
        req_wr = 1'b0;
    endtask

    task automatic do_read(input int a, output logic [31:0] d);
        @(negedge clk);
        req_rd = 1'b1; req_addr = AW'(a);
        @(negedge clk);
        req_rd = 1'b0;
        check("R1 valid", {31'd0, rsp_valid}, 32'd1);
        d = rsp_rdata;
    endtask

    task automatic read_chk(input int a, input logic [31:0] exp, input string req);
        logic [31:0] d;
        do_read(a, d);
        check(req, d, exp);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 idle valid", {31'd0, rsp_valid}, 32'd0);

        // R2 R12 R13: reset values across the whole address space
        for (int a = 0; a < (1 << AW); a++) read_chk(a, exp_reset(a), "R2 R12 R13 reset sweep");
        @(negedge clk);
        check("R1 valid drops", {31'd0, rsp_valid}, 32'd0);
        check("R2 adv out", {16'd0, cfg_adv_ability}, 32'h01A0);
        check("R2 timer out", {11'd0, cfg_link_timer}, 32'h098A00);
        check("R2 usx an en", {31'd0, usx_cfg_an_en}, 32'd1);

        // R7 R8 R10 R11 R12: all ones everywhere
        for (int a = 0; a < (1 << AW); a++) do_write(a, 32'hFFFF_FFFF);
        for (int a = 0; a < (1 << AW); a++) read_chk(a, exp_ones(a), "R7 R8 R10 R11 R12 ones sweep");
        check("R7 an en out", {31'd0, cfg_an_en}, 32'd1);
        check("R7 mode out", {28'd0, cfg_sgmii_speed, cfg_sgmii_use_an, cfg_sgmii_en}, 32'hF);
        check("R7 timer out", {11'd0, cfg_link_timer}, 32'h1FFFFF);
        check("R9 dl out", {28'd0, cfg_dl_rst, usx_cfg_dl_rst}, 32'hF);
        check("R10 usx timer out", {26'd0, usx_cfg_link_timer}, 32'h3F);
        check("R11 usx ctrl out", {27'd0, usx_cfg_speed, usx_cfg_an_en, usx_cfg_en}, 32'h1F);
        check("R3 soft rst held", {31'd0, cfg_soft_rst}, 32'd1);

        // R4: writing zeros leaves pending commands set
        for (int a = 0; a < (1 << AW); a++) do_write(a, 32'h0);
        for (int a = 0; a < (1 << AW); a++) read_chk(a, exp_zeros(a), "R4 R7 R9 R11 R12 zeros sweep");
        check("R4 restart pending", {30'd0, cfg_an_restart, usx_cfg_an_restart}, 32'h3);

        // R3: acknowledge clears only the soft reset
        @(negedge clk); hw_rst_done = 1'b1;
        @(negedge clk); hw_rst_done = 1'b0;
        check("R3 soft rst cleared", {31'd0, cfg_soft_rst}, 32'd0);
        check("R4 restart unaffected", {31'd0, cfg_an_restart}, 32'd1);
        @(negedge clk); hw_an_restart_ack = 1'b1;
        @(negedge clk); hw_an_restart_ack = 1'b0;
        check("R4 legacy restart cleared", {31'd0, cfg_an_restart}, 32'd0);
        @(negedge clk); usx_an_restart_ack = 1'b1;
        @(negedge clk); usx_an_restart_ack = 1'b0;
        check("R4 usx restart cleared", {31'd0, usx_cfg_an_restart}, 32'd0);

        // R3: contents survive the soft reset
        do_write('h10, 32'hA5A5);
        do_write('h14, 32'h5);
        do_write('h00, 32'h9000);
        repeat (5) @(negedge clk);
        check("R3 soft rst waits", {31'd0, cfg_soft_rst}, 32'd1);
        hw_rst_done = 1'b1;
        @(negedge clk); hw_rst_done = 1'b0;
        check("R3 soft rst done", {31'd0, cfg_soft_rst}, 32'd0);
        read_chk('h10, 32'hA5A5, "R3 scratch kept");
        read_chk('h14, 32'h5, "R3 mode kept");
        read_chk('h00, 32'h1000, "R3 ctrl after reset");

        // R4: write of 1 in the same cycle as the acknowledge wins
        @(negedge clk);
        req_wr = 1'b1; req_addr = AW'('h00); req_wdata = 32'h0200; hw_an_restart_ack = 1'b1;
        @(negedge clk);
        req_wr = 1'b0; hw_an_restart_ack = 1'b0;
        check("R4 set beats ack", {31'd0, cfg_an_restart}, 32'd1);
        @(negedge clk);
        req_wr = 1'b1; req_addr = AW'('h400); req_wdata = 32'h0200; usx_an_restart_ack = 1'b1;
        @(negedge clk);
        req_wr = 1'b0; usx_an_restart_ack = 1'b0;
        check("R4 usx set beats ack", {31'd0, usx_cfg_an_restart}, 32'd1);
        do_write('h00, 32'h0200);
        check("R4 rewrite keeps", {31'd0, cfg_an_restart}, 32'd1);

        // R5: live status and partner words
        hw_an_done = 1'b1; hw_link_up = 1'b1; usx_an_done = 1'b1; usx_link_up = 1'b1;
        hw_partner_ability = 16'hD5A0; usx_partner_ability = 16'hFFFF;
        read_chk('h01, 32'h2C, "R5 legacy status");
        read_chk('h401, 32'h24, "R5 usx status");
        read_chk('h05, 32'hD5A0, "R5 legacy partner");
        read_chk('h405, 32'hDF80, "R5 usx partner mask");
        hw_link_up = 1'b0;
        read_chk('h01, 32'h28, "R5 link lost");

        // R9: measurement flags live, reset bits hold
        hw_meas_valid = 2'b11;
        do_write('h17, 32'h4);
        do_write('h420, 32'h8);
        repeat (10) @(negedge clk);
        read_chk('h17, 32'h7, "R9 legacy dl");
        read_chk('h420, 32'hB, "R9 usx dl");

        // R6: clear-on-read page flag
        hw_partner_an_able = 1'b1;
        read_chk('h06, 32'h1, "R6 able only");
        hw_partner_an_able = 1'b0;
        @(negedge clk); hw_page_rx = 1'b1;
        @(negedge clk); hw_page_rx = 1'b0;
        read_chk('h05, 32'hD5A0, "R6 other read");
        do_write('h06, 32'h0);
        read_chk('h06, 32'h2, "R6 flag set");
        read_chk('h06, 32'h0, "R6 cleared by read");
        @(negedge clk);
        req_rd = 1'b1; req_addr = AW'('h06); hw_page_rx = 1'b1;
        @(negedge clk);
        req_rd = 1'b0; hw_page_rx = 1'b0;
        check("R6 race read old", rsp_rdata, 32'h0);
        read_chk('h06, 32'h2, "R6 set beats read");
        read_chk('h06, 32'h0, "R6 final clear");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule